// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block is an 18-bit register stage placed between two buses, A and B. Each direction has its own data path: A to B and B to A. Each path holds one storage element that acts as a latch and as a flip-flop. The latch enable and the direction clock of that path pick the mode from cycle to cycle. With the latch enable high the path is transparent. With it low and the direction clock steady, the path holds its value. With it low, a rising edge of the direction clock loads a new value.

The block runs on a system clock, `clk_i`. It samples the two direction clocks on that clock and finds their rising edges there. Transparent data passes through combinationally. Each bidirectional pin is modelled as three separate vectors: an input, a per-bit "driven" mask and an output, plus an output-enable vector for each port. The A-to-B output enable is active high. The B-to-A output enable is active low.

An optional bus-hold stage, selected by a parameter, sits on each input. For any bit that is not driven, it supplies the last value that was driven on that bit.

Top module: `ubr_top`

## Requirements
- R1: An active-low asynchronous reset sets both stored values and both hold values to zero. After reset, with both latch enables low, `a_o` and `b_o` read zero.
- R2: When `le_ab_i` is 1, `b_o` equals the effective A input in the same cycle, with no clock edge needed. When `le_ba_i` is 1, `a_o` equals the effective B input.
- R3: When a latch enable goes from 1 to 0, the path keeps the effective input that was sampled at the last `clk_i` edge while the enable was 1.
- R4: While a latch enable is 0 and its direction clock does not rise, the path output stays unchanged, whatever the input does.
- R5: While a latch enable is 0, a rising edge of the direction clock loads the effective input. A rising edge means the clock is sampled at 1 on a `clk_i` edge after being sampled at 0 on the previous edge. The new value appears at the output after that `clk_i` edge. A direction clock that is already high when reset is released does not count as an edge.
- R6: A direction-clock edge that arrives while the latch enable is 1 has no extra effect: the output keeps following the input.
- R7: `b_oe_o` is all ones when `oe_ab_i` is 1 and all zeros when it is 0.
- R8: `a_oe_o` is all ones when `oe_ba_ni` is 0 and all zeros when it is 1.
- R9: The two paths are independent. The enable, clock and data of one path never change the other path's output.
- R10: With bus hold on (`HOLD_EN`=1, the default), an input bit whose `*_vld_i` bit is 0 takes the last value driven on that bit. A bit whose `*_vld_i` bit is 1 passes its input value. The hold value updates on every `clk_i` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | A port input data |
| a_vld_i | input | 18 | Per-bit driven mask for a_i |
| b_i | input | 18 | B port input data |
| b_vld_i | input | 18 | Per-bit driven mask for b_i |
| le_ab_i | input | 1 | A-to-B latch enable |
| clk_ab_i | input | 1 | A-to-B direction clock |
| oe_ab_i | input | 1 | B port output enable, active high |
| le_ba_i | input | 1 | B-to-A latch enable |
| clk_ba_i | input | 1 | B-to-A direction clock |
| oe_ba_ni | input | 1 | A port output enable, active low |
| a_o | output | 18 | A port output data |
| a_oe_o | output | 18 | A port per-bit drive enable |
| b_o | output | 18 | B port output data |
| b_oe_o | output | 18 | B port per-bit drive enable |

## Verification
The hardest case to reach is when bus hold and a clock capture act together. A bit goes undriven after its value has changed, and a direction-clock edge then loads the held value rather than the raw input. The random stimulus leaves about a quarter of the bits undriven in each cycle and toggles the direction clocks on their own schedule, so captures of held bits occur often. Directed sequences cover a clock edge while a path is transparent and a direction clock that is already high when reset is released.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  parameter int unsigned UBR_W = 18;
endpackage

// File: rtl/ubr_hold.sv
module ubr_hold #(
  parameter int unsigned W       = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] vld_i,
  output logic [W-1:0] eff_o
);
  if (HOLD_EN) begin : g_hold
    logic [W-1:0] held_q;
    assign eff_o = (vld_i & din_i) | (~vld_i & held_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) held_q <= '0;
      else         held_q <= eff_o;
    end

    // R10
    hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ((~vld_i & (eff_o ^ $past(eff_o))) == '0));
  end else begin : g_pass
    logic [W-1:0] unused_vld;
    assign unused_vld = vld_i;
    assign eff_o      = din_i;
  end
endmodule

// File: rtl/ubr_path.sv
module ubr_path #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         le_i,
  input  logic         dclk_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] store_q;
  logic         dclk_q;
  logic         dclk_rise;

  assign dclk_rise = dclk_i & ~dclk_q;
  assign dout_o    = le_i ? din_i : store_q;

  // dclk_q resets high: a clock already high at reset exit is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
      dclk_q  <= 1'b1;
    end else begin
      dclk_q <= dclk_i;
      if (le_i || dclk_rise) store_q <= din_i;
    end
  end

  // R4
  hold_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !$rose(dclk_i)) ##1 !le_i |-> $stable(dout_o));

  // R5
  edge_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $rose(dclk_i)) ##1 !le_i |-> dout_o == $past(din_i));

  // R3
  latch_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i ##1 !le_i |-> dout_o == $past(din_i));
endmodule

// File: rtl/ubr_top.sv
module ubr_top #(
  parameter int unsigned W       = ubr_pkg::UBR_W,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_vld_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_vld_i,
  input  logic         le_ab_i,
  input  logic         clk_ab_i,
  input  logic         oe_ab_i,
  input  logic         le_ba_i,
  input  logic         clk_ba_i,
  input  logic         oe_ba_ni,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] a_eff, b_eff;

  ubr_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold_a (
    .clk_i, .rst_ni, .din_i(a_i), .vld_i(a_vld_i), .eff_o(a_eff));
  ubr_hold #(.W(W), .HOLD_EN(HOLD_EN)) u_hold_b (
    .clk_i, .rst_ni, .din_i(b_i), .vld_i(b_vld_i), .eff_o(b_eff));

  ubr_path #(.W(W)) u_ab (
    .clk_i, .rst_ni, .din_i(a_eff), .le_i(le_ab_i), .dclk_i(clk_ab_i), .dout_o(b_o));
  ubr_path #(.W(W)) u_ba (
    .clk_i, .rst_ni, .din_i(b_eff), .le_i(le_ba_i), .dclk_i(clk_ba_i), .dout_o(a_o));

  assign b_oe_o = {W{oe_ab_i}};
  assign a_oe_o = {W{~oe_ba_ni}};

  // R9
  path_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_ba_i && !$rose(clk_ba_i)) ##1 !le_ba_i |-> $stable(a_o));
endmodule

// File: tb/ubr_top_tb_top.sv
module ubr_top_tb_top;
  localparam int W = 18;
  localparam int NRAND = 4000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, a_vld = '1, b_in = '0, b_vld = '1;
  logic         le_ab = 1'b0, ck_ab = 1'b1, oe_ab = 1'b0;
  logic         le_ba = 1'b0, ck_ba = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int total = 0, bad = 0;

  // bench model
  logic [W-1:0] sa = '0, sb = '0, ha = '0, hb = '0;
  logic         pa = 1'b1, pb = 1'b1;

  always #10 clk = ~clk;

  ubr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_in), .a_vld_i(a_vld), .b_i(b_in), .b_vld_i(b_vld),
    .le_ab_i(le_ab), .clk_ab_i(ck_ab), .oe_ab_i(oe_ab),
    .le_ba_i(le_ba), .clk_ba_i(ck_ba), .oe_ba_ni(oe_ba_n),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe));

  function automatic logic [W-1:0] eff(input logic [W-1:0] d, input logic [W-1:0] v,
                                       input logic [W-1:0] h);
    return (v & d) | (~v & h);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic le, input logic ck, input logic p);
    if (le) return "R2";
    if (ck && !p) return "R5";
    return "R4";
  endfunction

  // check outputs mid low phase, then advance model at the rising edge
  task automatic tick(input string tag_b, input string tag_a);
    logic [W-1:0] ea, eb;
    #2;
    ea = eff(a_in, a_vld, ha);
    eb = eff(b_in, b_vld, hb);
    chk(tag_b, b_out, le_ab ? ea : sa);
    chk(tag_a, a_out, le_ba ? eb : sb);
    chk("R7", b_oe, {W{oe_ab}});
    chk("R8", a_oe, {W{~oe_ba_n}});
    @(posedge clk);
    if (le_ab || (ck_ab && !pa)) sa = ea;
    if (le_ba || (ck_ba && !pb)) sb = eb;
    pa = ck_ab; pb = ck_ba;
    ha = ea; hb = eb;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tick("R1", "R1");
    // R5 clock high at reset exit is no edge
    a_in = 18'h2aaaa; tick("R5", "R4");
    a_in = 18'h15555; tick("R5", "R4");
    // R5 real edge: low then high
    ck_ab = 1'b0; tick("R4", "R4");
    ck_ab = 1'b1; a_in = 18'h3c3c3; tick("R5", "R4");
    a_in = 18'h00001; tick("R5", "R4");
    // R2 transparent, R6 edge while transparent
    le_ab = 1'b1; a_in = 18'h12345; tick("R2", "R9");
    ck_ab = 1'b0; tick("R6", "R9");
    ck_ab = 1'b1; a_in = 18'h0abcd; tick("R6", "R9");
    a_in = 18'h3ffff; tick("R6", "R9");
    // R3 closing
    le_ab = 1'b0; a_in = 18'h00f0f; tick("R3", "R9");
    a_in = 18'h11111; tick("R3", "R9");
    // R10 hold: drive value then release bits
    le_ba = 1'b1; b_in = 18'h2f0f0; b_vld = '1; tick("R9", "R10");
    b_in = 18'h00000; b_vld = 18'h000ff; tick("R9", "R10");
    b_in = 18'h3ffff; tick("R9", "R10");
    le_ba = 1'b0; tick("R9", "R10");
    // R8 / R7 enables
    oe_ab = 1'b1; oe_ba_n = 1'b0; tick("R7", "R8");
    oe_ab = 1'b0; oe_ba_n = 1'b1; tick("R7", "R8");
    b_vld = '1;
    for (int i = 0; i < NRAND; i++) begin
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      a_vld   = W'($urandom | $urandom);
      b_vld   = W'($urandom | $urandom);
      le_ab   = ($urandom % 6) == 0;
      le_ba   = ($urandom % 6) == 0;
      if ($urandom % 3 == 0) ck_ab = ~ck_ab;
      if ($urandom % 3 == 0) ck_ba = ~ck_ba;
      oe_ab   = $urandom % 2 == 1;
      oe_ba_n = $urandom % 2 == 1;
      tick(mode_tag(le_ab, ck_ab, pa), mode_tag(le_ba, ck_ba, pb));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule